// File: doc/BRIEF.md
# 1-Wire Slot Sequence Engine

The engine sits between a host command decoder and a 1-Wire slot timer. Each accepted command turns into a short series of slot requests: one bus reset, one single bit, eight data bits for a byte write, eight read slots for a byte read, or three slots for a search step. For a search step, the engine picks the written direction itself from the two bits it has just read and a direction bit supplied by the host. The engine does not time any slot. It keeps the result flags, the busy flag and the received data byte.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the engine is idle and `abort` is low. A command is taken in any cycle where `cmd_valid` and `cmd_ready` are both high. While a sequence runs, back-pressure holds the command stream.

Slot requests leave on a second valid/ready stream. The engine keeps `slot_valid`, `slot_kind` and `slot_spu` steady until `slot_ready` is seen. It then waits for a one-cycle `res_valid` pulse from the slot timer before it issues the next slot. Only one slot is ever outstanding.

Top module: `ow_seq`

## Requirements
- R1: After reset the outputs are: `busy`=0, `cmd_ready`=1, `slot_valid`=0, and `sbr`, `tsb`, `dir`, `ppd`, `sd` and `rd_data` all zero.
- R2: Write byte (op 2) issues eight slots, taking the argument's bit 0 first. Each slot is kind 2 (write one) when its bit is 1 and kind 1 (write zero) when its bit is 0.
- R3: Read byte (op 3) issues eight kind-2 slots. The first sampled bit lands in `rd_data` bit 0. `rd_data` changes only when the eighth result arrives.
- R4: Single bit (op 1) issues one slot whose kind comes from argument bit 7 alone. Bits 6..0 are ignored. `sbr` takes the sampled `res_bit`.
- R5: Triplet (op 4) issues two kind-2 slots, then one write slot. The written bit depends on the two sampled bits:
  - 0 then 0: the written bit is argument bit 7.
  - 0 then 1: the written bit is 0.
  - 1 then 0: the written bit is 1.
  - 1 then 1: the written bit is 1.
- R6: After a triplet, `sbr` holds the first sampled bit, `tsb` holds the second, and `dir` holds the bit written in the third slot.
- R7: `busy` rises in the cycle after a command is accepted. It stays high until the cycle after the last slot result. `cmd_ready` is low whenever `busy` is high.
- R8: Bus reset (op 0) issues one kind-0 slot and loads `ppd` from `res_presence` and `sd` from `res_short`. `ppd` is forced to 0 when `sd` is 1. Commands other than the triplet leave `tsb` and `dir` unchanged.
- R9: `slot_spu` is 1 only on the last slot of a write byte or a single bit, and only when `cmd_spu` was 1 when that command was accepted. It is 0 on every other slot.
- R10: When `abort` is high at a clock edge, the engine is idle after that edge: `busy`=0 and `slot_valid`=0. Any slot result that arrives at the same edge is discarded.
- R11: While `slot_valid` is high and `slot_ready` is low, `slot_valid` stays high and `slot_kind` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Device-reset abort; returns the engine to idle |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 3 | Operation: 0 bus reset, 1 single bit, 2 write byte, 3 read byte, 4 triplet |
| cmd_arg | input | DATA_W | Data byte, bit byte or direction byte |
| cmd_spu | input | 1 | Strong pullup requested for this command |
| slot_valid | output | 1 | Slot request valid |
| slot_ready | input | 1 | Slot timer accepts the request |
| slot_kind | output | 2 | Slot kind: 0 reset, 1 write zero, 2 write one/read |
| slot_spu | output | 1 | Keep strong pullup after this slot |
| res_valid | input | 1 | One-cycle pulse: slot finished |
| res_bit | input | 1 | Sampled line value of the finished slot |
| res_presence | input | 1 | Presence seen during a reset slot |
| res_short | input | 1 | Short seen during a reset slot |
| busy | output | 1 | Sequence in progress |
| sbr | output | 1 | Single-bit / first-triplet result |
| tsb | output | 1 | Second triplet result |
| dir | output | 1 | Direction written by the last triplet |
| ppd | output | 1 | Presence detected by the last bus reset |
| sd | output | 1 | Short detected by the last bus reset |
| rd_data | output | DATA_W | Byte assembled by the last read byte |

## Verification
Two events can fall on the same clock edge: an abort and a slot result. To provoke this, the slave model raises `abort` in the same cycle as `res_valid` during a single-bit command whose sampled bit would set `sbr`. The check passes only if the engine is idle after that edge and `sbr` keeps its old value. Command acceptance and back-pressure overlap in the same way. A second command is held on the stream while a sequence runs, and the bench checks that `cmd_ready` stays low until `busy` falls.

// File: rtl/ow_seq_pkg.sv
package ow_seq_pkg;
  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_BIT   = 3'd1,
    OP_WBYTE = 3'd2,
    OP_RBYTE = 3'd3,
    OP_TRIP  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SK_RESET  = 2'd0,
    SK_WRITE0 = 2'd1,
    SK_WRITE1 = 2'd2
  } slot_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ow_shreg.sv
module ow_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              in_bit,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= load_val;
    else if (shift)  q <= {in_bit, q[DATA_W-1:1]};
  end
endmodule

// File: rtl/ow_triplet.sv
module ow_triplet (
  input  logic clk,
  input  logic rst_n,
  input  logic take_first,
  input  logic take_second,
  input  logic sample,
  input  logic host_dir,
  output logic first_q,
  output logic second_q,
  output logic chosen_dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      if (take_first)  first_q  <= sample;
      if (take_second) second_q <= sample;
    end
  end

  always_comb begin
    if (first_q && second_q)      chosen_dir = 1'b1;
    else if (first_q ^ second_q)  chosen_dir = first_q;
    else                          chosen_dir = host_dir;
  end
endmodule

// File: rtl/ow_status.sv
module ow_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_reset,
  input  logic              presence,
  input  logic              short_seen,
  input  logic              ev_sbr,
  input  logic              ev_tsb,
  input  logic              ev_dir,
  input  logic              sample,
  input  logic              dir_val,
  input  logic              ev_rd,
  input  logic [DATA_W-1:0] rd_val,
  output logic              sbr,
  output logic              tsb,
  output logic              dir,
  output logic              ppd,
  output logic              sd,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbr     <= 1'b0;
      tsb     <= 1'b0;
      dir     <= 1'b0;
      ppd     <= 1'b0;
      sd      <= 1'b0;
      rd_data <= '0;
    end else begin
      if (ev_reset) begin
        sd  <= short_seen;
        ppd <= presence && !short_seen;
      end
      if (ev_sbr) sbr     <= sample;
      if (ev_tsb) tsb     <= sample;
      if (ev_dir) dir     <= dir_val;
      if (ev_rd)  rd_data <= rd_val;
    end
  end

  AST_SD_BLOCKS_PPD: assert property (@(posedge clk) disable iff (!rst_n) sd |-> !ppd); // R8
  AST_TSB_ONLY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_tsb |=> $stable(tsb)); // R8
endmodule

// File: rtl/ow_seq.sv
module ow_seq
  import ow_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_arg,
  input  logic              cmd_spu,
  output logic              slot_valid,
  input  logic              slot_ready,
  output logic [1:0]        slot_kind,
  output logic              slot_spu,
  input  logic              res_valid,
  input  logic              res_bit,
  input  logic              res_presence,
  input  logic              res_short,
  output logic              busy,
  output logic              sbr,
  output logic              tsb,
  output logic              dir,
  output logic              ppd,
  output logic              sd,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W    = $clog2(DATA_W) + 1;
  localparam int TRIP_N   = 3;

  seq_state_e       st;
  op_e              op_q;
  logic             v_q;
  logic             spu_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] n_slots;
  logic             last_slot;
  logic             accept;
  logic             take;
  logic [DATA_W-1:0] sh;
  logic             t_first, t_second, t_dir;
  slot_kind_e       kind;

  assign cmd_ready = (st == ST_IDLE) && !abort;
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (st != ST_IDLE);
  assign take      = (st == ST_WAIT) && res_valid && !abort;

  always_comb begin
    unique case (op_q)
      OP_WBYTE, OP_RBYTE: n_slots = IDX_W'(DATA_W);
      OP_TRIP:            n_slots = IDX_W'(TRIP_N);
      default:            n_slots = IDX_W'(1);
    endcase
  end
  assign last_slot = (idx == n_slots - IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      op_q  <= OP_RESET;
      v_q   <= 1'b0;
      spu_q <= 1'b0;
      idx   <= '0;
    end else if (abort) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st    <= ST_ISSUE;
          op_q  <= op_e'(cmd_op);
          v_q   <= cmd_arg[DATA_W-1];
          spu_q <= cmd_spu;
          idx   <= '0;
        end
        ST_ISSUE: if (slot_ready) st <= ST_WAIT;
        ST_WAIT: if (res_valid) begin
          idx <= idx + IDX_W'(1);
          st  <= last_slot ? ST_IDLE : ST_ISSUE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  ow_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cmd_arg),
    .shift    (take && (op_q == OP_WBYTE || op_q == OP_RBYTE)),
    .in_bit   (res_bit),
    .q        (sh)
  );

  ow_triplet u_trip (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_first  (take && op_q == OP_TRIP && idx == IDX_W'(0)),
    .take_second (take && op_q == OP_TRIP && idx == IDX_W'(1)),
    .sample      (res_bit),
    .host_dir    (v_q),
    .first_q     (t_first),
    .second_q    (t_second),
    .chosen_dir  (t_dir)
  );

  always_comb begin
    unique case (op_q)
      OP_RESET: kind = SK_RESET;
      OP_BIT:   kind = v_q   ? SK_WRITE1 : SK_WRITE0;
      OP_WBYTE: kind = sh[0] ? SK_WRITE1 : SK_WRITE0;
      OP_TRIP:  kind = (idx < IDX_W'(2)) ? SK_WRITE1 : (t_dir ? SK_WRITE1 : SK_WRITE0);
      default:  kind = SK_WRITE1;
    endcase
  end

  assign slot_valid = (st == ST_ISSUE);
  assign slot_kind  = kind;
  assign slot_spu   = slot_valid && spu_q && last_slot && (op_q == OP_BIT || op_q == OP_WBYTE);

  ow_status #(.DATA_W(DATA_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_reset   (take && op_q == OP_RESET),
    .presence   (res_presence),
    .short_seen (res_short),
    .ev_sbr     (take && (op_q == OP_BIT || (op_q == OP_TRIP && idx == IDX_W'(0)))),
    .ev_tsb     (take && op_q == OP_TRIP && idx == IDX_W'(1)),
    .ev_dir     (take && op_q == OP_TRIP && idx == IDX_W'(2)),
    .sample     (res_bit),
    .dir_val    (t_dir),
    .ev_rd      (take && op_q == OP_RBYTE && last_slot),
    .rd_val     ({res_bit, sh[DATA_W-1:1]}),
    .sbr        (sbr),
    .tsb        (tsb),
    .dir        (dir),
    .ppd        (ppd),
    .sd         (sd),
    .rd_data    (rd_data)
  );

  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n || abort)
    slot_valid && !slot_ready |=> slot_valid && $stable(slot_kind)); // R11
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !slot_valid); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n || abort)
    cmd_valid && cmd_ready |=> busy); // R7
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R7
  AST_SPU_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    slot_spu |-> slot_valid && slot_kind != 2'd0); // R9
endmodule

// File: tb/ow_seq_bench.sv
module ow_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       abort = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_arg = 8'd0;
  logic       cmd_spu = 1'b0;
  logic       slot_valid;
  logic       slot_ready = 1'b0;
  logic [1:0] slot_kind;
  logic       slot_spu;
  logic       res_valid = 1'b0;
  logic       res_bit = 1'b0;
  logic       res_presence = 1'b0;
  logic       res_short = 1'b0;
  logic       busy, sbr, tsb, dir, ppd, sd;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  bit         resp_q[$];
  bit         pres_cfg = 1'b0;
  bit         short_cfg = 1'b0;
  bit         abort_on_result = 1'b0;
  int         gap = 0;

  always #2 clk = ~clk;

  ow_seq u_ow_seq (
    .clk(clk), .rst_n(rst_n), .abort(abort),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_spu(cmd_spu),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_kind(slot_kind),
    .slot_spu(slot_spu), .res_valid(res_valid), .res_bit(res_bit),
    .res_presence(res_presence), .res_short(res_short),
    .busy(busy), .sbr(sbr), .tsb(tsb), .dir(dir), .ppd(ppd), .sd(sd),
    .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor and slave model: pops expected slots and answers them
  initial begin
    forever begin
      @(negedge clk);
      if (slot_valid) begin
        repeat (gap % 3) @(negedge clk);
        gap++;
        chk(slot_valid, "R11 request held", slot_valid, 1);
        slot_ready = 1'b1;
        if (exp_q.size() == 0) chk(0, "R2 unexpected slot", slot_kind, 0);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk({slot_spu, slot_kind} == e, "R9 slot kind/spu", {slot_spu, slot_kind}, e);
        end
        if (slot_kind == 2'd2) res_bit = (resp_q.size() > 0) ? resp_q.pop_front() : 1'b1;
        else res_bit = 1'b0;
        res_presence = pres_cfg;
        res_short = short_cfg;
        @(negedge clk);
        slot_ready = 1'b0;
        repeat (2) @(negedge clk);
        res_valid = 1'b1;
        if (abort_on_result) abort = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        abort = 1'b0;
        abort_on_result = 1'b0;
      end
    end
  end

  // driver: offers a command and waits for the sequence to finish
  task automatic run_cmd(input logic [2:0] op, input logic [7:0] arg, input bit spu);
    @(negedge clk);
    cmd_op = op; cmd_arg = arg; cmd_spu = spu; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R7 busy after accept", {busy, cmd_ready}, 2);
    while (busy) @(negedge clk);
  endtask

  task automatic push_slot(input logic [1:0] k, input bit spu);
    exp_q.push_back({spu, k});
  endtask

  task automatic trip(input bit a, input bit b, input bit v, input bit exp_dir);
    resp_q.push_back(a); resp_q.push_back(b);
    push_slot(2'd2, 0); push_slot(2'd2, 0); push_slot(exp_dir ? 2'd2 : 2'd1, 0);
    run_cmd(3'd4, {v, 7'h2A}, 1'b1);
    chk(sbr == a, "R6 sbr first read", sbr, a);
    chk(tsb == b, "R6 tsb second read", tsb, b);
    chk(dir == exp_dir, "R5 triplet direction", dir, exp_dir);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] wb;
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    chk(!busy && cmd_ready && !slot_valid, "R1 reset control", {busy, cmd_ready, slot_valid}, 3'b010);
    chk({sbr, tsb, dir, ppd, sd} == 5'b0 && rd_data == 8'h00, "R1 reset status", {sbr, tsb, dir, ppd, sd, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 bus reset with presence
    pres_cfg = 1; short_cfg = 0;
    push_slot(2'd0, 0);
    run_cmd(3'd0, 8'h00, 1'b0);
    chk(ppd == 1 && sd == 0, "R8 presence", {ppd, sd}, 2'b10);
    pres_cfg = 1; short_cfg = 1;
    push_slot(2'd0, 0);
    run_cmd(3'd0, 8'h00, 1'b1);
    chk(ppd == 0 && sd == 1, "R8 short masks presence", {ppd, sd}, 2'b01);

    // R2 write byte with strong pullup on last slot
    wb = 8'hA5;
    for (int i = 0; i < 8; i++) push_slot(wb[i] ? 2'd2 : 2'd1, i == 7);
    run_cmd(3'd2, wb, 1'b1);
    chk(exp_q.size() == 0, "R2 eight write slots", exp_q.size(), 0);
    wb = 8'h3E;
    for (int i = 0; i < 8; i++) push_slot(wb[i] ? 2'd2 : 2'd1, 0);
    run_cmd(3'd2, wb, 1'b0);
    chk(exp_q.size() == 0, "R2 LSB first no spu", exp_q.size(), 0);

    // R3 read byte, spu request ignored
    rb = 8'h3C;
    for (int i = 0; i < 8; i++) begin resp_q.push_back(rb[i]); push_slot(2'd2, 0); end
    run_cmd(3'd3, 8'h00, 1'b1);
    chk(rd_data == rb, "R3 read byte", rd_data, rb);
    rb = 8'h81;
    for (int i = 0; i < 8; i++) begin resp_q.push_back(rb[i]); push_slot(2'd2, 0); end
    run_cmd(3'd3, 8'hFF, 1'b0);
    chk(rd_data == rb, "R3 read byte edge bits", rd_data, rb);

    // R4 single bit
    push_slot(2'd1, 1);
    run_cmd(3'd1, 8'h7F, 1'b1);
    chk(sbr == 0, "R4 write zero ignores low bits", sbr, 0);
    resp_q.push_back(1'b1); push_slot(2'd2, 0);
    run_cmd(3'd1, 8'h80, 1'b0);
    chk(sbr == 1, "R4 sampled one", sbr, 1);
    chk(tsb == 0 && dir == 0, "R8 tsb/dir untouched", {tsb, dir}, 0);

    // R5/R6 triplet cases
    trip(0, 0, 1, 1);
    trip(0, 1, 1, 0);
    trip(1, 0, 0, 1);
    trip(1, 1, 0, 1);
    trip(0, 0, 0, 0);
    resp_q.push_back(1'b0); push_slot(2'd2, 0);
    run_cmd(3'd1, 8'hC0, 1'b0);
    chk(tsb == 0 && dir == 0, "R8 single bit keeps tsb/dir", {tsb, dir}, 0);

    // R7 command held off while busy
    for (int i = 0; i < 8; i++) begin resp_q.push_back(1'b0); push_slot(2'd2, 0); end
    @(negedge clk);
    cmd_op = 3'd3; cmd_arg = 8'h00; cmd_spu = 0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 3'd1; cmd_arg = 8'h80;
    repeat (5) @(negedge clk);
    chk(busy && !cmd_ready, "R7 back-pressure", {busy, cmd_ready}, 2);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    chk(rd_data == 8'h00, "R7 held command not taken", rd_data, 0);

    // R10 abort in the same cycle as a result
    abort_on_result = 1'b1;
    resp_q.push_back(1'b1); push_slot(2'd2, 0);
    run_cmd(3'd1, 8'h80, 1'b0);
    chk(!busy && !slot_valid, "R10 idle after abort", {busy, slot_valid}, 0);
    chk(sbr == 0, "R10 result discarded", sbr, 0);
    resp_q.push_back(1'b1); push_slot(2'd2, 0);
    run_cmd(3'd1, 8'h80, 1'b0);
    chk(sbr == 1, "R10 usable after abort", sbr, 1);

    chk(exp_q.size() == 0, "R9 all slots seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule